// File: doc/BRIEF.md
# PCI Host Bridge Address Translator

This block sits between a CPU bus and a PCI host bridge. It accepts one CPU access at a time, carrying an address, a read or write flag, a size of 1, 2 or 4 bytes and write data. It works out which address window the access falls in and turns it into one or two PCI cycles, each with a cycle type, an address, byte enables and data. The reply from the PCI side is then returned to the CPU. Four CPU windows are decoded: a PCI I/O window, a configuration window, an interrupt-acknowledge location and a PCI memory window. An access that hits none of them gets a decode-error response, and no PCI cycle is started.

I/O addresses are translated in one of two ways, chosen by a mode input. In contiguous mode the port number is the low 16 bits of the window offset. In sparse mode each 4 KB CPU page carries 32 ports, and the page number supplies the upper port bits. A configuration address is formed by locating the lowest set bit of a one-hot device-select field and placing its index as a device number above the unchanged function and register bits. Data is little-endian. Each PCI cycle is word aligned and marks the bytes it carries with byte enables. An access that crosses a 32-bit boundary becomes two PCI cycles.

Top module: `pci_xlate_top`

## Requirements
- R1: With `io_sparse`=0, an access to CPU address 0x80000000+off, where off < 0x800000, produces cycle type 0 (I/O) at port address off[15:0].
- R2: With `io_sparse`=1, the I/O port address is {off[22:12], off[4:0]}. Bits [4:0] come from the CPU offset and bits [15:5] from offset bits [22:12].
- R3: An access to 0x80800000+off, where off < 0x400000, produces cycle type 1 (configuration) at address (idx<<11)|off[10:0]. Here idx is the position (0 to 10) of the lowest set bit among off[21:11], or 11 if none of those bits is set.
- R4: An access to 0xC0000000+off, where off < 0x3F000000, produces cycle type 2 (memory) at address off.
- R5: A 1-byte read of 0xBFFFFFF0 produces cycle type 3 (interrupt acknowledge) with byte enables 0001, and the response carries byte 0 of the returned data. A write, or any other size, at that address is a decode error.
- R6: Size encoding: 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. With lane = translated address [1:0], the PCI address has its low two bits at zero. The byte enables are the low size-bytes mask shifted left by lane, and write byte k is placed on byte lane lane+k. Read data is returned shifted down to bit 0, with bytes above the size zeroed.
- R7: An access whose bytes cross a 32-bit boundary is issued as two cycles. The second cycle is at the first cycle's word address plus 4 and carries the remaining byte enables and data. A read returns the bytes of both cycles joined.
- R8: An address outside every window, or size code 3, returns a response with the error flag set and read data of 0, and no PCI cycle is issued.
- R9: The mode input is sampled only when a request is accepted. Changing it while a request is in progress does not change that request's translation.
- R10: `cpu_req_ready` is low from acceptance until the response. `pci_req_valid` and the cycle fields stay unchanged until `pci_req_ready` is high. Each request produces exactly one single-cycle `cpu_rsp_valid` pulse.
- R11: After reset the block is idle, with `cpu_req_ready` high and `pci_req_valid` and `cpu_rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Block idle and able to accept a request |
| cpu_addr | input | 32 | CPU byte address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_wdata | input | 32 | Write data, least significant byte first |
| io_sparse | input | 1 | I/O mapping mode: 0 = contiguous, 1 = sparse |
| cpu_rsp_valid | output | 1 | Single-cycle response strobe |
| cpu_rsp_err | output | 1 | Decode error flag for the response |
| cpu_rdata | output | 32 | Read data aligned to bit 0 |
| pci_req_valid | output | 1 | PCI cycle request |
| pci_req_ready | input | 1 | PCI side accepts the cycle |
| pci_cmd | output | 2 | 0 = I/O, 1 = configuration, 2 = memory, 3 = interrupt acknowledge |
| pci_addr | output | 32 | Word-aligned PCI address |
| pci_be | output | 4 | Active-high byte enables |
| pci_write | output | 1 | PCI cycle direction |
| pci_wdata | output | 32 | PCI write data on its byte lanes |
| pci_rsp_valid | input | 1 | PCI cycle completion |
| pci_rdata | input | 32 | PCI read data on its byte lanes |

## Verification
The properties assume that the PCI side returns exactly one `pci_rsp_valid` for each cycle it accepts, and only after that cycle has been accepted. They also assume the CPU side raises a request only while `cpu_req_ready` is high. The bench target keeps to this: it records a cycle on the clock where it raises ready, answers on the following clock, and sometimes holds ready low for a few clocks to exercise the hold rule. The bench driver offers one request at a time and waits for its response. It flips the mode input only after acceptance, to check the sampling rule.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    typedef enum logic [1:0] {
        CYC_IO   = 2'd0,
        CYC_CFG  = 2'd1,
        CYC_MEM  = 2'd2,
        CYC_INTA = 2'd3
    } cyc_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ1  = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_REQ2  = 3'd3,
        ST_WAIT2 = 3'd4,
        ST_RESP  = 3'd5
    } st_t;

    typedef struct packed {
        st_t         st;
        cyc_t        cyc;
        logic [31:0] base;
        logic [3:0]  be0;
        logic [3:0]  be1;
        logic [31:0] d0;
        logic [31:0] d1;
        logic        split;
        logic        err;
        logic        wr;
        logic [1:0]  lane;
        logic [1:0]  size;
        logic [31:0] r0;
        logic [31:0] r1;
    } ctl_t;

endpackage

// File: rtl/pcx_cfg_encode.sv
module pcx_cfg_encode #(
    parameter int SEL_N = 11,
    localparam int IDX_W = $clog2(SEL_N + 1)
) (
    input  logic [SEL_N-1:0] sel,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = IDX_W'(SEL_N);
        for (int i = SEL_N - 1; i >= 0; i--) begin
            if (sel[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pcx_window_decode.sv
module pcx_window_decode
    import pcx_pkg::*;
#(
    parameter logic [31:0] IO_BASE   = 32'h8000_0000,
    parameter int          IO_SPAN_W = 23,
    parameter int          PAGE_SH   = 12,
    parameter int          SP_LO_W   = 5,
    parameter int          PORT_W    = 16,
    parameter logic [31:0] CFG_BASE  = 32'h8080_0000,
    parameter int          CFG_SPAN_W = 22,
    parameter int          SEL_LSB   = 11,
    parameter logic [31:0] MEM_BASE  = 32'hC000_0000,
    parameter logic [31:0] MEM_SIZE  = 32'h3F00_0000,
    parameter logic [31:0] INTA_ADDR = 32'hBFFF_FFF0
) (
    input  logic [31:0] addr,
    input  logic        write,
    input  logic [1:0]  size,
    input  logic        sparse,
    output cyc_t        cyc,
    output logic [31:0] xaddr,
    output logic        err
);
    localparam logic [31:0] IO_SPAN  = 32'(1) << IO_SPAN_W;
    localparam logic [31:0] CFG_SPAN = 32'(1) << CFG_SPAN_W;
    localparam int          SEL_N    = CFG_SPAN_W - SEL_LSB;
    localparam int          IDX_W    = $clog2(SEL_N + 1);

    logic [31:0] io_off, cfg_off, mem_off;
    logic        io_hit, cfg_hit, mem_hit, inta_hit;
    logic [31:0] io_port, cfg_addr;
    logic [IDX_W-1:0] dev_idx;

    assign io_off  = addr - IO_BASE;
    assign cfg_off = addr - CFG_BASE;
    assign mem_off = addr - MEM_BASE;

    assign io_hit   = io_off < IO_SPAN;
    assign cfg_hit  = cfg_off < CFG_SPAN;
    assign mem_hit  = mem_off < MEM_SIZE;
    assign inta_hit = addr == INTA_ADDR;

    pcx_cfg_encode #(.SEL_N(SEL_N)) u_enc (
        .sel (cfg_off[CFG_SPAN_W-1:SEL_LSB]),
        .idx (dev_idx)
    );

    assign cfg_addr = (32'(dev_idx) << SEL_LSB) | 32'(cfg_off[SEL_LSB-1:0]);

    always_comb begin
        if (sparse)
            io_port = 32'({io_off[IO_SPAN_W-1:PAGE_SH], io_off[SP_LO_W-1:0]});
        else
            io_port = 32'(io_off[PORT_W-1:0]);
    end

    always_comb begin
        cyc   = CYC_MEM;
        xaddr = '0;
        err   = 1'b0;
        if (size == 2'd3) begin
            err = 1'b1;
        end else if (inta_hit) begin
            cyc = CYC_INTA;
            err = write || (size != 2'd0);
        end else if (io_hit) begin
            cyc   = CYC_IO;
            xaddr = io_port;
        end else if (cfg_hit) begin
            cyc   = CYC_CFG;
            xaddr = cfg_addr;
        end else if (mem_hit) begin
            cyc   = CYC_MEM;
            xaddr = mem_off;
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/pcx_lane_pack.sv
module pcx_lane_pack #(
    parameter int BYTES = 4,
    localparam int LW = $clog2(BYTES),
    localparam int DW = BYTES * 8
) (
    input  logic [LW-1:0]  lane,
    input  logic [1:0]     size,
    input  logic [DW-1:0]  wdata,
    output logic [BYTES-1:0] be0,
    output logic [BYTES-1:0] be1,
    output logic [DW-1:0]  d0,
    output logic [DW-1:0]  d1,
    output logic           split
);
    logic [BYTES-1:0]   mask;
    logic [2*BYTES-1:0] wide;
    logic [2*DW-1:0]    data2;

    always_comb begin
        case (size)
            2'd0:    mask = BYTES'(1);
            2'd1:    mask = BYTES'(3);
            default: mask = '1;
        endcase
    end

    assign wide  = {{BYTES{1'b0}}, mask} << lane;
    assign data2 = {{DW{1'b0}}, wdata} << {lane, 3'b000};
    assign be0   = wide[BYTES-1:0];
    assign be1   = wide[2*BYTES-1:BYTES];
    assign d0    = data2[DW-1:0];
    assign d1    = data2[2*DW-1:DW];
    assign split = |be1;
endmodule

// File: rtl/pci_xlate_top.sv
module pci_xlate_top
    import pcx_pkg::*;
#(
    parameter logic [31:0] IO_BASE    = 32'h8000_0000,
    parameter int          IO_SPAN_W  = 23,
    parameter int          PAGE_SH    = 12,
    parameter int          SP_LO_W    = 5,
    parameter int          PORT_W     = 16,
    parameter logic [31:0] CFG_BASE   = 32'h8080_0000,
    parameter int          CFG_SPAN_W = 22,
    parameter int          SEL_LSB    = 11,
    parameter logic [31:0] MEM_BASE   = 32'hC000_0000,
    parameter logic [31:0] MEM_SIZE   = 32'h3F00_0000,
    parameter logic [31:0] INTA_ADDR  = 32'hBFFF_FFF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic [31:0] cpu_addr,
    input  logic        cpu_write,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    input  logic        io_sparse,
    output logic        cpu_rsp_valid,
    output logic        cpu_rsp_err,
    output logic [31:0] cpu_rdata,
    output logic        pci_req_valid,
    input  logic        pci_req_ready,
    output logic [1:0]  pci_cmd,
    output logic [31:0] pci_addr,
    output logic [3:0]  pci_be,
    output logic        pci_write,
    output logic [31:0] pci_wdata,
    input  logic        pci_rsp_valid,
    input  logic [31:0] pci_rdata
);
    cyc_t        dec_cyc;
    logic [31:0] dec_xaddr;
    logic        dec_err;
    logic [3:0]  ln_be0, ln_be1;
    logic [31:0] ln_d0, ln_d1;
    logic        ln_split;
    ctl_t        ctl_d, ctl_q;
    logic [31:0] rd_sh, rd_mask;
    logic        second;

    pcx_window_decode #(
        .IO_BASE(IO_BASE), .IO_SPAN_W(IO_SPAN_W), .PAGE_SH(PAGE_SH),
        .SP_LO_W(SP_LO_W), .PORT_W(PORT_W), .CFG_BASE(CFG_BASE),
        .CFG_SPAN_W(CFG_SPAN_W), .SEL_LSB(SEL_LSB), .MEM_BASE(MEM_BASE),
        .MEM_SIZE(MEM_SIZE), .INTA_ADDR(INTA_ADDR)
    ) u_dec (
        .addr   (cpu_addr),
        .write  (cpu_write),
        .size   (cpu_size),
        .sparse (io_sparse),
        .cyc    (dec_cyc),
        .xaddr  (dec_xaddr),
        .err    (dec_err)
    );

    pcx_lane_pack #(.BYTES(4)) u_lane (
        .lane  (dec_xaddr[1:0]),
        .size  (cpu_size),
        .wdata (cpu_wdata),
        .be0   (ln_be0),
        .be1   (ln_be1),
        .d0    (ln_d0),
        .d1    (ln_d1),
        .split (ln_split)
    );

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    ctl_d.cyc   = dec_cyc;
                    ctl_d.base  = {dec_xaddr[31:2], 2'b00};
                    ctl_d.be0   = ln_be0;
                    ctl_d.be1   = ln_be1;
                    ctl_d.d0    = cpu_write ? ln_d0 : '0;
                    ctl_d.d1    = cpu_write ? ln_d1 : '0;
                    ctl_d.split = ln_split;
                    ctl_d.err   = dec_err;
                    ctl_d.wr    = cpu_write;
                    ctl_d.lane  = dec_xaddr[1:0];
                    ctl_d.size  = cpu_size;
                    ctl_d.r0    = '0;
                    ctl_d.r1    = '0;
                    ctl_d.st    = dec_err ? ST_RESP : ST_REQ1;
                end
            end
            ST_REQ1:  if (pci_req_ready) ctl_d.st = ST_WAIT1;
            ST_WAIT1: begin
                if (pci_rsp_valid) begin
                    ctl_d.r0 = pci_rdata;
                    ctl_d.st = ctl_q.split ? ST_REQ2 : ST_RESP;
                end
            end
            ST_REQ2:  if (pci_req_ready) ctl_d.st = ST_WAIT2;
            ST_WAIT2: begin
                if (pci_rsp_valid) begin
                    ctl_d.r1 = pci_rdata;
                    ctl_d.st = ST_RESP;
                end
            end
            ST_RESP:  ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_sh = 32'({ctl_q.r1, ctl_q.r0} >> {ctl_q.lane, 3'b000});

    always_comb begin
        case (ctl_q.size)
            2'd0:    rd_mask = 32'h0000_00FF;
            2'd1:    rd_mask = 32'h0000_FFFF;
            default: rd_mask = 32'hFFFF_FFFF;
        endcase
    end

    assign second        = ctl_q.st == ST_REQ2;
    assign cpu_req_ready = ctl_q.st == ST_IDLE;
    assign cpu_rsp_valid = ctl_q.st == ST_RESP;
    assign cpu_rsp_err   = cpu_rsp_valid && ctl_q.err;
    assign cpu_rdata     = (cpu_rsp_valid && !ctl_q.err && !ctl_q.wr) ? (rd_sh & rd_mask) : '0;
    assign pci_req_valid = (ctl_q.st == ST_REQ1) || second;
    assign pci_cmd       = ctl_q.cyc;
    assign pci_addr      = second ? ctl_q.base + 32'd4 : ctl_q.base;
    assign pci_be        = second ? ctl_q.be1 : ctl_q.be0;
    assign pci_write     = ctl_q.wr;
    assign pci_wdata     = second ? ctl_q.d1 : ctl_q.d0;
endmodule

// File: rtl/pcx_xlate_chk.sv
module pcx_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req_ready,
    input logic        cpu_rsp_valid,
    input logic        cpu_rsp_err,
    input logic [31:0] cpu_rdata,
    input logic        pci_req_valid,
    input logic        pci_req_ready,
    input logic [1:0]  pci_cmd,
    input logic [31:0] pci_addr,
    input logic [3:0]  pci_be,
    input logic        pci_write
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_valid && !pci_req_ready |=> pci_req_valid && $stable(pci_addr)
            && $stable(pci_be) && $stable(pci_cmd) && $stable(pci_write));

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_valid |-> !cpu_req_ready);

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    // R6
    lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_valid |-> (pci_be != 4'b0000) && (pci_addr[1:0] == 2'b00));

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid && cpu_rsp_err |-> cpu_rdata == 32'h0);

    // R5
    inta_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_valid && pci_cmd == 2'd3 |-> pci_be == 4'b0001 && !pci_write);

    // R1
    io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_valid && pci_cmd == 2'd0 |-> pci_addr[31:17] == '0);

    // R3
    cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pci_req_valid && pci_cmd == 2'd1 |-> pci_addr[31:15] == '0);
endmodule

bind pci_xlate_top pcx_xlate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_err   (cpu_rsp_err),
    .cpu_rdata     (cpu_rdata),
    .pci_req_valid (pci_req_valid),
    .pci_req_ready (pci_req_ready),
    .pci_cmd       (pci_cmd),
    .pci_addr      (pci_addr),
    .pci_be        (pci_be),
    .pci_write     (pci_write)
);

// File: tb/sim_pci_xlate_top.sv
`timescale 1ns/1ps
module sim_pci_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_addr = '0;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        io_sparse = 1'b0;
    logic        cpu_rsp_valid, cpu_rsp_err;
    logic [31:0] cpu_rdata;
    logic        pci_req_valid;
    logic        pci_req_ready = 1'b1;
    logic [1:0]  pci_cmd;
    logic [31:0] pci_addr;
    logic [3:0]  pci_be;
    logic        pci_write;
    logic [31:0] pci_wdata;
    logic        pci_rsp_valid = 1'b0;
    logic [31:0] pci_rdata = '0;

    int total = 0;
    int bad = 0;
    int n_cyc = 0;
    int stall_lim = 0;
    int stall_cnt = 0;
    bit pending = 0;
    logic [31:0] pend_addr;
    logic [1:0]  lg_cmd [4];
    logic [31:0] lg_addr [4];
    logic [3:0]  lg_be [4];
    logic [31:0] lg_wd [4];
    logic        lg_wr [4];
    bit          x_err;
    logic [31:0] x_rd;

    always #5 clk = ~clk;

    pci_xlate_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .io_sparse(io_sparse),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_err(cpu_rsp_err), .cpu_rdata(cpu_rdata),
        .pci_req_valid(pci_req_valid), .pci_req_ready(pci_req_ready),
        .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_be(pci_be),
        .pci_write(pci_write), .pci_wdata(pci_wdata),
        .pci_rsp_valid(pci_rsp_valid), .pci_rdata(pci_rdata)
    );

    function automatic logic [31:0] tgt(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h0F0F_3C3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_cyc(input int i, input logic [1:0] cmd, input logic [31:0] a,
                           input logic [3:0] be, input logic [31:0] wd, input string tag);
        chk(lg_cmd[i] == cmd, {tag, " cmd"}, 32'(lg_cmd[i]), 32'(cmd));
        chk(lg_addr[i] == a, {tag, " addr"}, lg_addr[i], a);
        chk(lg_be[i] == be, {tag, " be"}, 32'(lg_be[i]), 32'(be));
        chk(lg_wd[i] == wd, {tag, " wdata"}, lg_wd[i], wd);
    endtask

    // PCI target model: records accepted cycles, answers one clock later
    initial begin
        forever begin
            @(negedge clk);
            pci_rsp_valid = 1'b0;
            if (pending) begin
                pci_rsp_valid = 1'b1;
                pci_rdata = tgt(pend_addr);
                pending = 0;
            end
            if (pci_req_valid && !pending) begin
                if (stall_cnt < stall_lim) begin
                    pci_req_ready = 1'b0;
                    stall_cnt++;
                end else begin
                    pci_req_ready = 1'b1;
                    stall_cnt = 0;
                    pending = 1;
                    pend_addr = pci_addr;
                    if (n_cyc < 4) begin
                        lg_cmd[n_cyc] = pci_cmd;
                        lg_addr[n_cyc] = pci_addr;
                        lg_be[n_cyc] = pci_be;
                        lg_wd[n_cyc] = pci_wdata;
                        lg_wr[n_cyc] = pci_write;
                    end
                    n_cyc++;
                end
            end
        end
    end

    task automatic xact(input logic [31:0] a, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, input bit flip);
        bit got;
        n_cyc = 0;
        got = 0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_addr = a;
        cpu_write = wr;
        cpu_size = sz;
        cpu_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (flip) io_sparse = ~io_sparse;
        chk(cpu_req_ready == 1'b0, "R10 ready low while busy", 32'(cpu_req_ready), 32'h0);
        for (int k = 0; k < 60 && !got; k++) begin
            if (cpu_rsp_valid) begin
                got = 1;
                x_err = cpu_rsp_err;
                x_rd = cpu_rdata;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, "R10 response seen", 32'(got), 32'h1);
        @(negedge clk);
        chk(!cpu_rsp_valid, "R10 single response pulse", 32'(cpu_rsp_valid), 32'h0);
        if (flip) io_sparse = ~io_sparse;
    endtask

    task automatic t_reset;
        chk(cpu_req_ready == 1'b1, "R11 ready after reset", 32'(cpu_req_ready), 32'h1);
        chk(pci_req_valid == 1'b0, "R11 no pci request", 32'(pci_req_valid), 32'h0);
        chk(cpu_rsp_valid == 1'b0, "R11 no response", 32'(cpu_rsp_valid), 32'h0);
    endtask

    task automatic t_io_contig;
        io_sparse = 1'b0;
        xact(32'h8000_1230, 1'b1, 2'd2, 32'hDEAD_BEEF, 1'b0);
        chk(n_cyc == 1, "R1 one cycle", 32'(n_cyc), 32'h1);
        chk_cyc(0, 2'd0, 32'h0000_1230, 4'hF, 32'hDEAD_BEEF, "R1 word write");
        chk(lg_wr[0] == 1'b1, "R1 write flag", 32'(lg_wr[0]), 32'h1);
        xact(32'h8012_3456, 1'b0, 2'd0, 32'h0, 1'b0);
        chk_cyc(0, 2'd0, 32'h0000_3454, 4'b0100, 32'h0, "R6 R1 byte read lane2");
        chk(x_rd == 32'(tgt(32'h3454) >> 16 & 32'hFF), "R6 byte read data", x_rd, tgt(32'h3454) >> 16 & 32'hFF);
    endtask

    task automatic t_io_sparse;
        io_sparse = 1'b1;
        xact(32'h8012_3456, 1'b1, 2'd1, 32'h0000_A1B2, 1'b0);
        chk_cyc(0, 2'd0, 32'h0000_2474, 4'b1100, 32'hA1B2_0000, "R2 R6 sparse half write");
        xact(32'h807F_F01F, 1'b0, 2'd0, 32'h0, 1'b0);
        chk_cyc(0, 2'd0, 32'h0000_FFFC, 4'b1000, 32'h0, "R2 sparse top port");
        io_sparse = 1'b0;
    endtask

    task automatic t_cfg;
        xact(32'h8088_410C, 1'b0, 2'd2, 32'h0, 1'b0);
        chk_cyc(0, 2'd1, 32'h0000_190C, 4'hF, 32'h0, "R3 lowest select bit");
        chk(x_rd == tgt(32'h190C), "R3 cfg read data", x_rd, tgt(32'h190C));
        xact(32'h8080_0208, 1'b0, 2'd2, 32'h0, 1'b0);
        chk_cyc(0, 2'd1, 32'h0000_5A08, 4'hF, 32'h0, "R3 no select bit");
        xact(32'h80A0_0004, 1'b1, 2'd2, 32'h1234_5678, 1'b0);
        chk_cyc(0, 2'd1, 32'h0000_5004, 4'hF, 32'h1234_5678, "R3 top select bit");
    endtask

    task automatic t_mem;
        xact(32'hC123_4567, 1'b1, 2'd0, 32'h0000_00AB, 1'b0);
        chk_cyc(0, 2'd2, 32'h0123_4564, 4'b1000, 32'hAB00_0000, "R4 R6 mem byte write");
        xact(32'hFEFF_FFFC, 1'b0, 2'd2, 32'h0, 1'b0);
        chk_cyc(0, 2'd2, 32'h3EFF_FFFC, 4'hF, 32'h0, "R4 mem window top");
        chk(x_err == 1'b0, "R4 no error", 32'(x_err), 32'h0);
    endtask

    task automatic t_inta;
        xact(32'hBFFF_FFF0, 1'b0, 2'd0, 32'h0, 1'b0);
        chk(n_cyc == 1 && lg_cmd[0] == 2'd3, "R5 inta cycle", 32'(lg_cmd[0]), 32'h3);
        chk(lg_be[0] == 4'b0001, "R5 inta enables", 32'(lg_be[0]), 32'h1);
        chk(x_rd == (tgt(lg_addr[0]) & 32'hFF), "R5 vector", x_rd, tgt(lg_addr[0]) & 32'hFF);
        xact(32'hBFFF_FFF0, 1'b0, 2'd1, 32'h0, 1'b0);
        chk(x_err == 1'b1 && n_cyc == 0, "R5 wide inta rejected", 32'(n_cyc), 32'h0);
        xact(32'hBFFF_FFF0, 1'b1, 2'd0, 32'h55, 1'b0);
        chk(x_err == 1'b1 && n_cyc == 0, "R5 inta write rejected", 32'(n_cyc), 32'h0);
    endtask

    task automatic t_split;
        xact(32'h8000_0103, 1'b1, 2'd2, 32'h4433_2211, 1'b0);
        chk(n_cyc == 2, "R7 two cycles", 32'(n_cyc), 32'h2);
        chk_cyc(0, 2'd0, 32'h0000_0100, 4'b1000, 32'h1100_0000, "R7 first half");
        chk_cyc(1, 2'd0, 32'h0000_0104, 4'b0111, 32'h0044_3322, "R7 second half");
        xact(32'hC000_0007, 1'b0, 2'd1, 32'h0, 1'b0);
        chk(n_cyc == 2, "R7 split read cycles", 32'(n_cyc), 32'h2);
        chk(lg_addr[1] == 32'h8 && lg_be[1] == 4'b0001, "R7 split read second", lg_addr[1], 32'h8);
        chk(x_rd == {16'h0, tgt(32'h8)[7:0], tgt(32'h4)[31:24]}, "R7 joined data",
            x_rd, {16'h0, tgt(32'h8)[7:0], tgt(32'h4)[31:24]});
    endtask

    task automatic t_err;
        xact(32'h0000_1000, 1'b0, 2'd2, 32'h0, 1'b0);
        chk(x_err == 1'b1 && n_cyc == 0 && x_rd == 0, "R8 low hole", 32'(n_cyc), 32'h0);
        xact(32'hFF00_0000, 1'b1, 2'd2, 32'h1, 1'b0);
        chk(x_err == 1'b1 && n_cyc == 0, "R8 above mem window", 32'(x_err), 32'h1);
        xact(32'hC000_0000, 1'b0, 2'd3, 32'h0, 1'b0);
        chk(x_err == 1'b1 && n_cyc == 0, "R8 bad size code", 32'(x_err), 32'h1);
    endtask

    task automatic t_mode_hold;
        io_sparse = 1'b1;
        xact(32'h8012_3456, 1'b0, 2'd0, 32'h0, 1'b1);
        chk(lg_addr[0] == 32'h0000_2474, "R9 sparse kept after flip", lg_addr[0], 32'h2474);
        io_sparse = 1'b0;
        xact(32'h8012_3456, 1'b0, 2'd0, 32'h0, 1'b1);
        chk(lg_addr[0] == 32'h0000_3454, "R9 contiguous kept after flip", lg_addr[0], 32'h3454);
    endtask

    task automatic t_stall;
        stall_lim = 3;
        xact(32'h8000_0103, 1'b0, 2'd2, 32'h0, 1'b0);
        chk(n_cyc == 2 && lg_addr[1] == 32'h104, "R10 stalled split", lg_addr[1], 32'h104);
        chk(x_rd == 32'({tgt(32'h104), tgt(32'h100)} >> 24), "R10 R7 stalled data",
            x_rd, 32'({tgt(32'h104), tgt(32'h100)} >> 24));
        stall_lim = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_io_contig();
        t_io_sparse();
        t_cfg();
        t_mem();
        t_inta();
        t_split();
        t_err();
        t_mode_hold();
        t_stall();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule